// File: doc/BRIEF.md
# Beacon Target Timer Unit

This block keeps a 64-bit time-synchronisation counter in microseconds and four beacon-related target timers. The counter advances once per 1 MHz tick enable. Its time-unit view (TU, 1024 µs) is `tsf[25:10]`, and its eighth-TU view is `tsf[25:7]`. Two timers, the next beacon target and the ATIM window end, hold 16-bit TU values. The other two, the DMA beacon alert and the software beacon alert, hold 19-bit values in 1/8 TU. When the matching view of the counter equals a timer, that timer moves forward by one beacon period and raises a single-cycle event. A timer that the counter jumps past stays where it is until the counter view wraps round to it again.

Software loads the timers, the counter and a control word through one register-style write port. The control word carries the period, the enable and the counter-clear toggle. A combinational window checker compares the ATIM end and the DMA alert against the next beacon target, and allows for 16-bit wrap. It flags the gap that a stalled timer leaves behind.

Top module: `beacon_timer_unit`

## Requirements
- R1: After reset the counter, all four timers, the period, the enable and the event outputs are zero.
- R2: The counter increments by one on each clock with `tick_us` high. A write with selector 5 replaces `tsf[31:0]` and a write with selector 6 replaces `tsf[63:32]`; writes take priority over counting.
- R3: The TU timers (selector 0 next beacon, selector 3 ATIM end) match against `tsf[25:10]`. The eighth-TU timers (selector 1 DMA alert, selector 2 software alert) match against `tsf[25:7]`. When the counter reaches a match by counting, the event appears one clock after the counter first holds the matching value.
- R4: On a match while enabled, the timer advances by the period (by the period times 8 for eighth-TU timers), wrapping at its width. The timer's bit of `evt` pulses for one clock in the same cycle. The bits of `evt` are 0 next beacon, 1 DMA alert, 2 software alert, 3 ATIM end.
- R5: While the enable bit (control word bit 16) is clear, no event is raised and no timer moves.
- R6: A timer changes only on its own match or its own write. A timer the counter jumped past holds its value until the counter view wraps back onto it.
- R7: A control write (selector 4: period in bits 15:0, enable in bit 16) with bit 17 set toggles an internal clear flag. The counter is cleared only when the flag goes from 0 to 1, so a second such write leaves the counter untouched.
- R8: For timers A and B, window W and period P, a pair passes when B−A=W, or A−B=P−W, or (A|0x10000)−B=P−W, or (B|0x10000)−A=W. `win_ok` is high when (A=next beacon, B=ATIM end, W=1) passes and (A=DMA alert>>3, B=next beacon, W=DMA response time) passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-microsecond count enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target selector (0..6) |
| wr_data | input | 32 | Write data |
| tsf | output | 64 | Time-synchronisation counter in µs |
| tmr_nbtt | output | 16 | Next beacon target, TU |
| tmr_dma | output | 19 | DMA beacon alert, 1/8 TU |
| tmr_swba | output | 19 | Software beacon alert, 1/8 TU |
| tmr_atim | output | 16 | ATIM window end, TU |
| evt | output | 4 | Single-cycle timer events |
| win_ok | output | 1 | Timer window check result |

## Verification
In the counting pattern, a consistent timer set runs from counter zero for several periods. It shows that each timer fires at the exact microsecond its view reaches the stored value and steps by the right amount. In the jump pattern, the counter skips over the ATIM end and the DMA alert but not the next beacon. This separates a correct stall from a design that catches up, and drives `win_ok` low. A later load into a wrapped epoch shows the stalled timers resuming and the window recovering. Random periods, beacon targets and counter offsets, together with repeated clear writes and a disabled phase, separate the toggle behaviour and the enable gating from plain counting.

// File: rtl/beacon_timer_unit.sv
module beacon_timer_unit #(
  parameter int TMR_W    = 16,
  parameter int FRAC_W   = 3,
  parameter int TU_LSB   = 10,
  parameter int TSF_W    = 64,
  parameter int DW       = 32,
  parameter int DMA_RESP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_us,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [TSF_W-1:0]         tsf,
  output logic [TMR_W-1:0]         tmr_nbtt,
  output logic [TMR_W+FRAC_W-1:0]  tmr_dma,
  output logic [TMR_W+FRAC_W-1:0]  tmr_swba,
  output logic [TMR_W-1:0]         tmr_atim,
  output logic [3:0]               evt,
  output logic                     win_ok
);
  localparam int FT_W    = TMR_W + FRAC_W;
  localparam int FT_LSB  = TU_LSB - FRAC_W;
  localparam int EN_BIT  = TMR_W;
  localparam int CLR_BIT = TMR_W + 1;
  localparam int SPAN    = 1 << TMR_W;

  localparam logic [2:0] SEL_NBTT = 3'd0;
  localparam logic [2:0] SEL_DMA  = 3'd1;
  localparam logic [2:0] SEL_SWBA = 3'd2;
  localparam logic [2:0] SEL_ATIM = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_TSFL = 3'd5;
  localparam logic [2:0] SEL_TSFH = 3'd6;

  logic [TMR_W-1:0] period;
  logic             bcn_en;
  logic             clr_tgl;
  logic [3:0]       hit;

  wire [TMR_W-1:0] tu  = tsf[TU_LSB +: TMR_W];
  wire [FT_W-1:0]  tuf = tsf[FT_LSB +: FT_W];

  wire ctrl_wr = wr_en && wr_sel == SEL_CTRL;
  wire do_clr  = ctrl_wr && wr_data[CLR_BIT] && !clr_tgl;

  assign hit = {bcn_en && tu  == tmr_atim,
                bcn_en && tuf == tmr_swba,
                bcn_en && tuf == tmr_dma,
                bcn_en && tu  == tmr_nbtt};

  function automatic logic win_pass(input int a, input int b, input int w, input int iv);
    return (b - a == w) || (a - b == iv - w) ||
           (((a | SPAN) - b) == iv - w) || (((b | SPAN) - a) == w);
  endfunction

  assign win_ok = win_pass(int'(tmr_nbtt), int'(tmr_atim), 1, int'(period)) &&
                  win_pass(int'(tmr_dma[FT_W-1:FRAC_W]), int'(tmr_nbtt), DMA_RESP, int'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      bcn_en  <= 1'b0;
      clr_tgl <= 1'b0;
    end else if (ctrl_wr) begin
      period <= wr_data[TMR_W-1:0];
      bcn_en <= wr_data[EN_BIT];
      if (wr_data[CLR_BIT]) clr_tgl <= !clr_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           tsf <= '0;
    else if (wr_en && wr_sel == SEL_TSFL) tsf <= {tsf[TSF_W-1:DW], wr_data};
    else if (wr_en && wr_sel == SEL_TSFH) tsf <= {wr_data[TSF_W-DW-1:0], tsf[DW-1:0]};
    else if (do_clr)                      tsf <= '0;
    else                                  tsf <= tsf + TSF_W'(tick_us);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_nbtt <= '0;
      tmr_dma  <= '0;
      tmr_swba <= '0;
      tmr_atim <= '0;
      evt      <= '0;
    end else begin
      evt <= hit;
      if (wr_en && wr_sel == SEL_NBTT) tmr_nbtt <= wr_data[TMR_W-1:0];
      else if (hit[0])                 tmr_nbtt <= tmr_nbtt + period;
      if (wr_en && wr_sel == SEL_DMA)  tmr_dma  <= wr_data[FT_W-1:0];
      else if (hit[1])                 tmr_dma  <= tmr_dma + {period, FRAC_W'(0)};
      if (wr_en && wr_sel == SEL_SWBA) tmr_swba <= wr_data[FT_W-1:0];
      else if (hit[2])                 tmr_swba <= tmr_swba + {period, FRAC_W'(0)};
      if (wr_en && wr_sel == SEL_ATIM) tmr_atim <= wr_data[TMR_W-1:0];
      else if (hit[3])                 tmr_atim <= tmr_atim + period;
    end
  end
endmodule

module beacon_timer_unit_chk #(
  parameter int TMR_W  = 16,
  parameter int FRAC_W = 3,
  parameter int TSF_W  = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_us,
  input logic                    wr_en,
  input logic [2:0]              wr_sel,
  input logic                    bcn_en,
  input logic [TMR_W-1:0]        period,
  input logic [TSF_W-1:0]        tsf,
  input logic [TMR_W-1:0]        tmr_nbtt,
  input logic [TMR_W+FRAC_W-1:0] tmr_dma,
  input logic [TMR_W-1:0]        tmr_atim,
  input logic [3:0]              evt
);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bcn_en |=> evt == 4'd0);

  a_r4_nbtt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && evt[0] && !$past(wr_en && wr_sel == 3'd0))
      |-> tmr_nbtt == TMR_W'($past(tmr_nbtt) + $past(period)));

  a_r4_atim_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && evt[3] && !$past(wr_en && wr_sel == 3'd3))
      |-> tmr_atim == TMR_W'($past(tmr_atim) + $past(period)));

  a_r6_nbtt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !evt[0] && !$past(wr_en && wr_sel == 3'd0)) |-> $stable(tmr_nbtt));

  a_r6_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !evt[1] && !$past(wr_en && wr_sel == 3'd1)) |-> $stable(tmr_dma));

  a_r2_tsf_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |-> tsf == $past(tsf) + TSF_W'($past(tick_us)));
endmodule

bind beacon_timer_unit beacon_timer_unit_chk #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .TSF_W(TSF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .wr_sel(wr_sel),
  .bcn_en(bcn_en), .period(period), .tsf(tsf), .tmr_nbtt(tmr_nbtt),
  .tmr_dma(tmr_dma), .tmr_atim(tmr_atim), .evt(evt));

// File: tb/tb_beacon_timer_unit.sv
module tb_beacon_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [63:0] tsf;
  logic [15:0] tmr_nbtt, tmr_atim;
  logic [18:0] tmr_dma, tmr_swba;
  logic [3:0]  evt;
  logic        win_ok;

  int nchk = 0, nfail = 0;
  int ecnt [4];
  logic [15:0] bper = 16'd0, bper_prev = 16'd0;
  logic        ben = 1'b0, ben_prev = 1'b0;
  logic [18:0] prev [4];
  bit          mon_on = 1'b0;

  always #4 clk = ~clk;

  beacon_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tsf(tsf), .tmr_nbtt(tmr_nbtt), .tmr_dma(tmr_dma),
    .tmr_swba(tmr_swba), .tmr_atim(tmr_atim), .evt(evt), .win_ok(win_ok));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit win_fn(input int a, input int b, input int w, input int iv);
    return (b - a == w) || (a - b == iv - w) ||
           (((a | 65536) - b) == iv - w) || (((b | 65536) - a) == w);
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1;
    if (s == 3'd4) begin bper = d[15:0]; ben = d[16]; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_evt(input int b, input int maxc, input string req);
    for (int k = 0; k < maxc; k++) begin
      @(posedge clk); #3;
      if (evt[b]) return;
    end
    check(req, 64'd0, 64'd1);
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 4; i++) ecnt[i] = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); #3;
      if (mon_on) begin
        logic [18:0] cur [4];
        cur[0] = {3'b0, tmr_nbtt}; cur[1] = tmr_dma; cur[2] = tmr_swba; cur[3] = {3'b0, tmr_atim};
        for (int i = 0; i < 4; i++) begin
          bit fine;
          logic [18:0] msk, inc;
          logic [25:0] pos;
          fine = (i == 1 || i == 2);
          msk  = fine ? 19'h7FFFF : 19'h0FFFF;
          inc  = fine ? {bper_prev, 3'b0} : {3'b0, bper_prev};
          pos  = fine ? ({prev[i], 7'b0} + 26'd1) : ({prev[i][15:0], 10'b0} + 26'd1);
          if (!(wr_en && wr_sel == 3'(i))) begin
            if (evt[i]) begin
              ecnt[i]++;
              check("R4 timer step", 64'(cur[i]), 64'((prev[i] + inc) & msk));
              check("R3 match position", 64'(tsf[25:0]), 64'(pos));
            end else begin
              check("R6 timer hold", 64'(cur[i]), 64'(prev[i]));
            end
          end
        end
        if (!ben_prev) check("R5 no event while disabled", 64'(evt), 64'd0);
        check("R8 window", 64'(win_ok),
              64'(win_fn(int'(tmr_nbtt), int'(tmr_atim), 1, int'(bper)) &&
                  win_fn(int'(tmr_dma[18:3]), int'(tmr_nbtt), 2, int'(bper))));
        for (int i = 0; i < 4; i++) prev[i] = cur[i];
      end else begin
        prev[0] = {3'b0, tmr_nbtt}; prev[1] = tmr_dma; prev[2] = tmr_swba; prev[3] = {3'b0, tmr_atim};
      end
      bper_prev = bper;
      ben_prev  = ben;
    end
  end

  initial begin
    #(190000 * 8);
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int cnt;
    logic [31:0] lo, hi;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tsf", tsf, 64'd0);
    check("R1 timers", {tmr_nbtt, tmr_atim, 13'd0, tmr_dma, tmr_swba}, 64'd0);
    check("R1 evt", 64'(evt), 64'd0);
    mon_on = 1'b1;

    // R2 counting under random tick pattern, then loads
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      tick_us = 1'($urandom % 2);
      cnt += int'(tick_us);
    end
    @(negedge clk);
    tick_us = 1'b0;
    check("R2 tick count", tsf, 64'(cnt));
    lo = $urandom; hi = $urandom;
    wr(3'd5, lo);
    wr(3'd6, hi);
    check("R2 tsf load", tsf, {hi, lo});

    // R7 clear toggle
    wr(3'd5, 32'd1234);
    wr(3'd4, 32'h0002_0000);
    check("R7 first clear write", tsf, 64'd0);
    wr(3'd5, 32'd777);
    wr(3'd4, 32'h0002_0000);
    check("R7 second write leaves counter", tsf, 64'd777);
    wr(3'd4, 32'h0002_0000);
    check("R7 third write clears", tsf, 64'd0);

    // R3/R4 directed counting from zero
    wr(3'd4, 32'd3);
    wr(3'd0, 32'd5); wr(3'd1, 32'd24); wr(3'd2, 32'd32); wr(3'd3, 32'd6);
    wr(3'd5, 32'd0); wr(3'd6, 32'd0);
    clr_cnt();
    wr(3'd4, 32'h0001_0003);
    tick_us = 1'b1;
    repeat (13000) @(negedge clk);
    tick_us = 1'b0;
    check("R4 nbtt events", 64'(ecnt[0]), 64'd3);
    check("R4 dma events", 64'(ecnt[1]), 64'd4);
    check("R4 swba events", 64'(ecnt[2]), 64'd3);
    check("R4 atim events", 64'(ecnt[3]), 64'd3);
    check("R4 nbtt final", 64'(tmr_nbtt), 64'd14);
    check("R4 dma final", 64'(tmr_dma), 64'd120);
    check("R4 swba final", 64'(tmr_swba), 64'd104);
    check("R4 atim final", 64'(tmr_atim), 64'd15);

    // R5 disabled
    wr(3'd4, 32'd3);
    clr_cnt();
    tick_us = 1'b1;
    repeat (5000) @(negedge clk);
    tick_us = 1'b0;
    check("R5 event count", 64'(ecnt[0] + ecnt[1] + ecnt[2] + ecnt[3]), 64'd0);
    check("R5 nbtt held", 64'(tmr_nbtt), 64'd14);

    // R6/R8 jump past ATIM and DMA, then wrap back
    wr(3'd0, 32'd10); wr(3'd1, 32'd64); wr(3'd2, 32'd72); wr(3'd3, 32'd11);
    wr(3'd5, 32'd8068); wr(3'd6, 32'd0);
    wr(3'd4, 32'h0001_0003);
    tick_us = 1'b1;
    wait_evt(0, 5000, "R4 first beacon event");
    @(negedge clk);
    tick_us = 1'b0;
    wr(3'd5, 32'd12588);
    tick_us = 1'b1;
    wait_evt(0, 3000, "R6 beacon after jump");
    @(negedge clk);
    tick_us = 1'b0;
    check("R6 atim stalled", 64'(tmr_atim), 64'd11);
    check("R6 dma stalled", 64'(tmr_dma), 64'd88);
    check("R6 nbtt kept stepping", 64'(tmr_nbtt), 64'd16);
    check("R8 drift flagged", 64'(win_ok), 64'd0);
    wr(3'd5, 32'h0400_0000 + 32'd10540);
    tick_us = 1'b1;
    wait_evt(3, 3000, "R6 atim after wrap");
    repeat (2) @(negedge clk);
    tick_us = 1'b0;
    check("R6 atim resumed", 64'(tmr_atim), 64'd14);
    check("R6 dma resumed", 64'(tmr_dma), 64'd112);
    check("R8 window restored", 64'(win_ok), 64'd1);

    // Random consistent schedules
    for (int it = 0; it < 4; it++) begin
      int p, nb, f;
      p  = 2 + int'($urandom % 5);
      nb = 4 + int'($urandom % 59997);
      f  = int'($urandom % 500);
      wr(3'd4, 32'(p));
      wr(3'd0, 32'(nb));
      wr(3'd1, 32'((nb - 2) << 3));
      wr(3'd2, 32'((nb - 1) << 3));
      wr(3'd3, 32'(nb + 1));
      wr(3'd5, 32'((nb - 3) * 1024 + f));
      wr(3'd6, $urandom);
      clr_cnt();
      wr(3'd4, 32'h0001_0000 | 32'(p));
      tick_us = 1'b1;
      repeat (2 * p * 1024 + 1500) @(negedge clk);
      tick_us = 1'b0;
      check("R4 random beacon count", 64'(ecnt[0]), 64'd2);
      check("R8 random window", 64'(win_ok), 64'd1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule